// File: doc/BRIEF.md
# Strobed Parallel Printer Output Controller

This block links a host's byte-wide write port to a parallel line printer that uses a strobe and acknowledge handshake. A host write while the block is idle captures the byte and drives it onto the printer data lines at once. The block then waits a fixed settling time and pulses an active-low strobe for a fixed width. After that it waits for the printer to acknowledge before it takes another byte.

The settling time and the strobe width are parameters counted in system clock cycles. The defaults are 16 and 8 cycles, which give 2 us and 1 us at an 8 MHz clock. The acknowledge input is asynchronous. It passes through a two-flop synchronizer and acts only on its rising edge, and only once the strobe has finished. The host sees one ready flag. A write made while the block is busy is dropped and sets a sticky overrun flag, which the host clears with a separate input.

Top module: `lpt_out_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `prn_stb_n` is 1, `ready` is 1, `overrun` is 0 and `prn_data` is 0.
- R2: A write (`host_wr`=1) sampled at a clock edge while `ready`=1 puts `host_data` on `prn_data` and drops `ready` to 0 after that same edge.
- R3: `prn_stb_n` first reads 0 after the edge that falls exactly SETUP_CYC clock edges after the accepting write edge.
- R4: `prn_stb_n` stays 0 for exactly STROBE_CYC cycles and then returns to 1, and it stays 1 until the next accepted write.
- R5: `prn_data` holds the accepted byte unchanged from the write edge until the transfer ends, including every cycle in which the strobe is low.
- R6: After the strobe has been released, a rising edge on `prn_ack` that is first sampled at edge A0 sets `ready` to 1 after edge A0+2. At the same time `prn_data` is cleared to 0.
- R7: A rising edge on `prn_ack` that occurs and ends before the strobe has been released is ignored: `ready` stays 0 until a later rising edge arrives.
- R8: A write sampled while `ready`=0 leaves `prn_data` and the transfer timing unchanged, and it sets `overrun` to 1 after that edge.
- R9: `overrun` stays 1 until `ovr_clr` is sampled high. It then reads 0 after that edge. If a new overrun and a clear occur at the same edge, the set wins.
- R10: A write sampled at the first edge where `ready`=1 after a transfer is accepted, so bytes can be sent back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | One-cycle write strobe from the host |
| host_data | input | 8 | Byte written by the host |
| ovr_clr | input | 1 | Clears the sticky overrun flag |
| prn_ack | input | 1 | Acknowledge from the printer, asynchronous, active high |
| prn_data | output | 8 | Data lines to the printer |
| prn_stb_n | output | 1 | Active-low data-valid strobe to the printer |
| ready | output | 1 | High when a new byte may be written |
| overrun | output | 1 | Sticky flag for a write that was dropped because the block was busy |

## Verification
Each result is due at a fixed edge, counted from the edge that accepts the write (E0). `prn_data` and `ready` change right after E0. The strobe falls after E(SETUP_CYC) and rises after E(SETUP_CYC+STROBE_CYC). `ready` returns two edges after the acknowledge is first sampled, and `overrun` changes one edge after the offending write. The bench drives every input and samples every output 1 ns after a rising edge, and it numbers the edges itself. Each check therefore falls at a known edge index, and the bench compares the whole strobe waveform against the expected edge window rather than waiting for a change.

// File: rtl/lpt_pkg.sv
package lpt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_STROBE = 2'd2,
        ST_WAIT   = 2'd3
    } lpt_state_e;

endpackage

// File: rtl/lpt_ack_sync.sv
module lpt_ack_sync (
    input  logic clk,
    input  logic rst,
    input  logic ack_async,
    output logic ack_rise
);

    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_t;

    sync_t r_d, r_q;

    always_comb begin
        r_d    = r_q;
        r_d.s1 = ack_async;
        r_d.s2 = r_q.s1;
        r_d.s3 = r_q.s2;
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign ack_rise = r_q.s2 & ~r_q.s3;

    AST_ACK_EDGE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        ack_rise |=> !ack_rise); // R6

endmodule

// File: rtl/lpt_phase_timer.sv
module lpt_phase_timer #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [CW-1:0] last,
    output logic          expired
);

    logic [CW-1:0] cnt_d, cnt_q;

    assign expired = en && (cnt_q == last);

    always_comb begin
        if (!en || expired) cnt_d = '0;
        else                cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (rst)
        en |-> cnt_q <= last); // R4

endmodule

// File: rtl/lpt_hs_fsm.sv
module lpt_hs_fsm
    import lpt_pkg::*;
#(
    parameter int DW         = 8,
    parameter int CW         = 5,
    parameter int SETUP_CYC  = 16,
    parameter int STROBE_CYC = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          host_wr,
    input  logic [DW-1:0] host_data,
    input  logic          ovr_clr,
    input  logic          ack_rise,
    input  logic          tmr_expired,
    output logic          tmr_en,
    output logic [CW-1:0] tmr_last,
    output logic [DW-1:0] prn_data,
    output logic          prn_stb_n,
    output logic          ready,
    output logic          overrun
);

    localparam logic [CW-1:0] SETUP_LAST  = CW'(SETUP_CYC - 1);
    localparam logic [CW-1:0] STROBE_LAST = CW'(STROBE_CYC - 1);

    typedef struct packed {
        lpt_state_e    st;
        logic [DW-1:0] data;
        logic          stb_n;
        logic          ovr;
    } fsm_t;

    fsm_t r_d, r_q;

    always_comb begin
        tmr_en   = (r_q.st == ST_SETUP) || (r_q.st == ST_STROBE);
        tmr_last = (r_q.st == ST_STROBE) ? STROBE_LAST : SETUP_LAST;
    end

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (host_wr) begin
                    r_d.st   = ST_SETUP;
                    r_d.data = host_data;
                end
            end
            ST_SETUP: begin
                if (tmr_expired) r_d.st = ST_STROBE;
            end
            ST_STROBE: begin
                if (tmr_expired) r_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (ack_rise) begin
                    r_d.st   = ST_IDLE;
                    r_d.data = '0;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
        r_d.stb_n = (r_d.st != ST_STROBE);
        if (host_wr && (r_q.st != ST_IDLE)) r_d.ovr = 1'b1;
        else if (ovr_clr)                   r_d.ovr = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.st    <= ST_IDLE;
            r_q.data  <= '0;
            r_q.stb_n <= 1'b1;
            r_q.ovr   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign prn_data  = r_q.data;
    assign prn_stb_n = r_q.stb_n;
    assign ready     = (r_q.st == ST_IDLE);
    assign overrun   = r_q.ovr;

    AST_WRITE_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (ready && host_wr) |=> (!ready && prn_data == $past(host_data))); // R2
    AST_STB_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        !prn_stb_n |-> !ready); // R3
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!ready && !$past(ready)) |-> $stable(prn_data)); // R5
    AST_RELEASE_CLEAN: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> (prn_stb_n && prn_data == '0)); // R6
    AST_OVR_SET: assert property (@(posedge clk) disable iff (rst)
        (!ready && host_wr) |=> overrun); // R8
    AST_OVR_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (ovr_clr && !(host_wr && !ready)) |=> !overrun); // R9

endmodule

// File: rtl/lpt_out_ctrl.sv
module lpt_out_ctrl #(
    parameter int DW         = 8,
    parameter int SETUP_CYC  = 16,
    parameter int STROBE_CYC = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          host_wr,
    input  logic [DW-1:0] host_data,
    input  logic          ovr_clr,
    input  logic          prn_ack,
    output logic [DW-1:0] prn_data,
    output logic          prn_stb_n,
    output logic          ready,
    output logic          overrun
);

    localparam int MAXC = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
    localparam int CW   = (MAXC < 2) ? 1 : $clog2(MAXC);

    logic          ack_rise;
    logic          tmr_en;
    logic          tmr_expired;
    logic [CW-1:0] tmr_last;

    lpt_ack_sync u_sync (
        .clk       (clk),
        .rst       (rst),
        .ack_async (prn_ack),
        .ack_rise  (ack_rise)
    );

    lpt_phase_timer #(.CW(CW)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .en      (tmr_en),
        .last    (tmr_last),
        .expired (tmr_expired)
    );

    lpt_hs_fsm #(
        .DW         (DW),
        .CW         (CW),
        .SETUP_CYC  (SETUP_CYC),
        .STROBE_CYC (STROBE_CYC)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .host_wr     (host_wr),
        .host_data   (host_data),
        .ovr_clr     (ovr_clr),
        .ack_rise    (ack_rise),
        .tmr_expired (tmr_expired),
        .tmr_en      (tmr_en),
        .tmr_last    (tmr_last),
        .prn_data    (prn_data),
        .prn_stb_n   (prn_stb_n),
        .ready       (ready),
        .overrun     (overrun)
    );

    initial begin
        assert (SETUP_CYC >= 1 && STROBE_CYC >= 1)
            else $error("lpt_out_ctrl: delay parameters must be at least 1");
    end

endmodule

// File: tb/lpt_out_ctrl_bench.sv
`timescale 1ns/1ps
module lpt_out_ctrl_bench;

    localparam int S = 16;
    localparam int W = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_wr = 1'b0;
    logic [7:0] host_data = 8'h00;
    logic       ovr_clr = 1'b0;
    logic       prn_ack = 1'b0;
    logic [7:0] prn_data;
    logic       prn_stb_n;
    logic       ready;
    logic       overrun;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    lpt_out_ctrl #(.DW(8), .SETUP_CYC(S), .STROBE_CYC(W)) u_lpt_out_ctrl (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_data(host_data),
        .ovr_clr(ovr_clr), .prn_ack(prn_ack), .prn_data(prn_data),
        .prn_stb_n(prn_stb_n), .ready(ready), .overrun(overrun)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Write one byte; returns after E0 (sampled 1 ns later).
    task automatic host_write(input logic [7:0] b);
        host_wr   = 1'b1;
        host_data = b;
        step();
        host_wr   = 1'b0;
    endtask

    // Walk edges E1..E(S+W+2); mode 1: early ack pulse, mode 2: busy write.
    task automatic run_strobe(input logic [7:0] b, input int mode);
        int first_low = -1;
        int low_cnt   = 0;
        bit data_ok   = 1'b1;
        bit rdy_ok    = 1'b1;
        for (int i = 1; i <= S + W + 2; i++) begin
            step();
            if (!prn_stb_n) begin
                if (first_low < 0) first_low = i;
                low_cnt++;
            end
            if (prn_data !== b) data_ok = 1'b0;
            if (ready !== 1'b0) rdy_ok = 1'b0;
            if (mode == 1 && i == 4) prn_ack = 1'b1;
            if (mode == 1 && i == 7) prn_ack = 1'b0;
            if (mode == 2 && i == 3) begin host_wr = 1'b1; host_data = ~b; end
            if (mode == 2 && i == 4) host_wr = 1'b0;
        end
        chk(first_low == S, "R3 strobe start edge", first_low, S);
        chk(low_cnt == W, "R4 strobe width", low_cnt, W);
        chk(prn_stb_n === 1'b1, "R4 strobe released", prn_stb_n, 1);
        chk(data_ok, "R5 data held during transfer", data_ok, 1);
        chk(rdy_ok, "R7 ready low while busy", rdy_ok, 1);
    endtask

    task automatic send_ack();
        prn_ack = 1'b1;
        step();
        chk(ready === 1'b0, "R6 ready still low at A0", ready, 0);
        step();
        chk(ready === 1'b0, "R6 ready still low at A1", ready, 0);
        step();
        chk(ready === 1'b1, "R6 ready high at A2", ready, 1);
        chk(prn_data === 8'h00, "R6 data cleared", prn_data, 0);
        chk(prn_stb_n === 1'b1, "R6 strobe high at release", prn_stb_n, 1);
        prn_ack = 1'b0;
    endtask

    task automatic t_reset();
        step();
        chk(prn_stb_n === 1'b1 && ready === 1'b1, "R1 reset strobe/ready", {prn_stb_n, ready}, 3);
        chk(overrun === 1'b0 && prn_data === 8'h00, "R1 reset overrun/data", {overrun, prn_data}, 0);
        rst = 1'b0;
        step();
        chk(ready === 1'b1 && prn_stb_n === 1'b1, "R1 after reset idle", {prn_stb_n, ready}, 3);
    endtask

    task automatic t_basic(input logic [7:0] b);
        host_write(b);
        chk(prn_data === b, "R2 byte on data lines", prn_data, b);
        chk(ready === 1'b0, "R2 ready low after write", ready, 0);
        run_strobe(b, 0);
        send_ack();
        repeat (3) step();
    endtask

    task automatic t_early_ack(input logic [7:0] b);
        host_write(b);
        run_strobe(b, 1);
        repeat (8) step();
        chk(ready === 1'b0, "R7 early ack ignored", ready, 0);
        send_ack();
        repeat (3) step();
    endtask

    task automatic t_overrun(input logic [7:0] b);
        host_write(b);
        run_strobe(b, 2);
        chk(overrun === 1'b1, "R8 busy write sets overrun", overrun, 1);
        send_ack();
        chk(overrun === 1'b1, "R9 overrun sticky", overrun, 1);
        repeat (3) step();
        ovr_clr = 1'b1;
        step();
        ovr_clr = 1'b0;
        chk(overrun === 1'b0, "R9 overrun cleared", overrun, 0);
        // Set and clear at the same edge: set wins.
        host_write(8'h11);
        host_wr = 1'b1; ovr_clr = 1'b1;
        step();
        host_wr = 1'b0; ovr_clr = 1'b0;
        chk(overrun === 1'b1, "R9 set wins over clear", overrun, 1);
        chk(prn_data === 8'h11, "R8 busy write dropped", prn_data, 8'h11);
        repeat (S + W) step();
        send_ack();
        ovr_clr = 1'b1;
        step();
        ovr_clr = 1'b0;
        repeat (2) step();
    endtask

    task automatic t_back_to_back();
        host_write(8'h3C);
        run_strobe(8'h3C, 0);
        send_ack();
        host_write(8'hC3);
        chk(prn_data === 8'hC3 && ready === 1'b0, "R10 back-to-back accepted", prn_data, 8'hC3);
        run_strobe(8'hC3, 0);
        send_ack();
        repeat (3) step();
    endtask

    initial begin
        t_reset();
        t_basic(8'hA5);
        t_basic(8'hFF);
        t_early_ack(8'h5A);
        t_overrun(8'h81);
        t_back_to_back();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule